// File: doc/BRIEF.md
# Golden-Comparison Result Monitor

This block runs one fault-injection experiment from beginning to end. The unit under test may carry an injected fault. A fault-free twin of that unit serves as the reference. On a start pulse the monitor does four things in order. It first writes zero to every location of both application result memories, one address per clock, so that results from an earlier experiment cannot leak into this one. It then releases both cores from reset and waits for each to raise its completion signal. The injection window lies inside this run phase.

When both cores have finished, the monitor reads the two memories in lockstep, one address per clock, and compares each pair of words. The reference may finish while the unit under test does not finish within a fixed grace period. In that case the experiment is classed as a lost sequence and no read-back takes place. A one-cycle done pulse marks the moment the result becomes valid. The result is a 2-bit outcome code, plus the lowest address at which the two memories disagree.

Top module: `golden_result_monitor`

## Requirements
- R1: After reset the outputs are idle. `core_rst_n`, `mem_we`, `mem_rd` and `done` are low, and `status` and `err_addr` are zero.
- R2: A start pulse taken in idle launches a clear phase in the next cycle. `mem_we` is high for exactly DEPTH cycles, `mem_addr` steps from 0 to DEPTH-1 by one per cycle, `mem_wdata` is zero, and `core_rst_n` stays low. Contents left from before the run therefore cannot cause a mismatch.
- R3: `core_rst_n` is high only in the run phase. The run phase lies between the end of the clear phase and the start of the read-back or the result.
- R4: Once both `ref_end` and `dut_end` have been seen high in the run phase, `mem_rd` is high for exactly DEPTH cycles and `mem_addr` steps from 0 to DEPTH-1. Read data is expected on `dut_rdata` and `ref_rdata` in the cycle after its address.
- R5: If every location matches, `status` is 0 (no error) at done and `err_addr` is 0.
- R6: If any location differs, `status` is 1 (data error) and `err_addr` holds the lowest differing address. This also applies when the difference is at address DEPTH-1.
- R7: If `ref_end` has been seen and `dut_end` is not seen within TIMEOUT cycles after it, `status` is 2 (lost sequence), no read-back is performed, and `err_addr` is 0.
- R8: A `dut_end` that comes within TIMEOUT cycles after `ref_end`, or that comes before `ref_end`, is not a lost sequence. The normal read-back follows.
- R9: `done` is a single-cycle pulse. `status` and `err_addr` change only in the cycle in which `done` is high, and hold until the next done.
- R10: A start pulse that arrives while an experiment is in progress is ignored. Clear and read-back each still run exactly DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an experiment when idle |
| dut_end | input | 1 | Completion signal of the unit under test |
| ref_end | input | 1 | Completion signal of the reference unit |
| dut_rdata | input | DW | Read data from the unit-under-test memory, one cycle after address |
| ref_rdata | input | DW | Read data from the reference memory, one cycle after address |
| core_rst_n | output | 1 | Active-low reset to both cores |
| mem_we | output | 1 | Clear write strobe to both memories |
| mem_rd | output | 1 | Read strobe to both memories |
| mem_addr | output | AW | Shared memory address |
| mem_wdata | output | DW | Clear data (always zero) |
| done | output | 1 | One-cycle pulse, result valid |
| status | output | 2 | 0 no error, 1 data error, 2 lost sequence |
| err_addr | output | AW | Lowest mismatching address |

## Verification
A fault in the address counter shows at the memory ports within one clock: a skipped, repeated or non-zero starting address breaks the strict 0..DEPTH-1 walk of `mem_addr`. A stale mismatch flag or a compare register sampled in the wrong cycle shows as the wrong `status` or `err_addr` at the next done. Mismatches placed at the first and last addresses expose any pipeline slip. A timer that counts wrongly shows as a lost sequence where the late unit should have passed, or as the reverse, one grace period after the reference ends.

// File: rtl/mon_pkg.sv
package mon_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_READ,
        ST_DRAIN,
        ST_FINISH
    } mon_state_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_DATA = 2'd1,
        RES_LOST = 2'd2
    } mon_result_e;

endpackage

// File: rtl/mon_addr_gen.sv
module mon_addr_gen #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } ag_t;

    ag_t d, q;

    assign addr = q.addr;
    assign last = (q.addr == AW'(DEPTH - 1));

    always_comb begin
        d = q;
        if (clr) begin
            d.addr = '0;
        end else if (step) begin
            d.addr = last ? '0 : q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2 / R4: counter never leaves the legal address range
    a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.addr <= AW'(DEPTH - 1));

endmodule

// File: rtl/mon_timeout.sv
module mon_timeout #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t d, q;

    assign expired = (q.cnt == CW'(LIMIT));

    always_comb begin
        d = q;
        if (clr)                 d.cnt = '0;
        else if (en && !expired) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: the grace counter saturates and stays expired until cleared
    a_r7_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired);

endmodule

// File: rtl/mon_cmp.sv
module mon_cmp #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dut_rdata,
    input  logic [DW-1:0] ref_rdata,
    output logic          hit,
    output logic [AW-1:0] first_addr
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          hit;
        logic [AW-1:0] first;
    } cmp_t;

    cmp_t d, q;
    logic differ;

    assign differ     = q.vld && (dut_rdata != ref_rdata);
    assign hit        = q.hit;
    assign first_addr = q.first;

    always_comb begin
        d      = q;
        d.vld  = rd_en;
        d.addr = addr;
        if (clr) begin
            d.hit   = 1'b0;
            d.first = '0;
        end else if (differ && !q.hit) begin
            d.hit   = 1'b1;
            d.first = q.addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: once captured, the first mismatch address is never overwritten
    a_r6_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hit && !clr) |=> (q.hit && $stable(q.first)));

endmodule

// File: rtl/golden_result_monitor.sv
module golden_result_monitor
    import mon_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int DW      = 8,
    parameter int TIMEOUT = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dut_end,
    input  logic          ref_end,
    input  logic [DW-1:0] dut_rdata,
    input  logic [DW-1:0] ref_rdata,
    output logic          core_rst_n,
    output logic          mem_we,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          done,
    output logic [1:0]    status,
    output logic [AW-1:0] err_addr
);
    typedef struct packed {
        mon_state_e    st;
        logic          ref_seen;
        logic          dut_seen;
        logic          lost;
        logic          done;
        logic [1:0]    status;
        logic [AW-1:0] err;
    } ctl_t;

    ctl_t d, q;

    logic          addr_clr, addr_step, addr_last;
    logic          tmr_clr, tmr_en, tmr_expired;
    logic          cmp_clr, cmp_hit;
    logic [AW-1:0] cmp_first;

    mon_addr_gen #(.DEPTH(DEPTH)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .step  (addr_step),
        .addr  (mem_addr),
        .last  (addr_last)
    );

    mon_timeout #(.LIMIT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .expired (tmr_expired)
    );

    mon_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cmp_clr),
        .rd_en      (mem_rd),
        .addr       (mem_addr),
        .dut_rdata  (dut_rdata),
        .ref_rdata  (ref_rdata),
        .hit        (cmp_hit),
        .first_addr (cmp_first)
    );

    assign mem_we     = (q.st == ST_CLEAR);
    assign mem_rd     = (q.st == ST_READ);
    assign core_rst_n = (q.st == ST_RUN);
    assign mem_wdata  = '0;
    assign done       = q.done;
    assign status     = q.status;
    assign err_addr   = q.err;
    assign tmr_en     = (q.st == ST_RUN) && q.ref_seen && !q.dut_seen;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        addr_clr  = 1'b0;
        addr_step = 1'b0;
        tmr_clr   = 1'b0;
        cmp_clr   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_CLEAR;
                    d.ref_seen = 1'b0;
                    d.dut_seen = 1'b0;
                    d.lost     = 1'b0;
                    addr_clr   = 1'b1;
                    tmr_clr    = 1'b1;
                    cmp_clr    = 1'b1;
                end
            end
            ST_CLEAR: begin
                addr_step = 1'b1;
                if (addr_last) d.st = ST_RUN;
            end
            ST_RUN: begin
                d.ref_seen = q.ref_seen | ref_end;
                d.dut_seen = q.dut_seen | dut_end;
                if (q.ref_seen && q.dut_seen) begin
                    d.st = ST_READ;
                end else if (q.ref_seen && !dut_end && tmr_expired) begin
                    d.lost = 1'b1;
                    d.st   = ST_FINISH;
                end
            end
            ST_READ: begin
                addr_step = 1'b1;
                if (addr_last) d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                d.st = ST_FINISH;
            end
            ST_FINISH: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
                if (q.lost) begin
                    d.status = RES_LOST;
                    d.err    = '0;
                end else if (cmp_hit) begin
                    d.status = RES_DATA;
                    d.err    = cmp_first;
                end else begin
                    d.status = RES_OK;
                    d.err    = '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    // R2: clear walks consecutive addresses
    a_r2_clear_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R4: read-back walks consecutive addresses
    a_r4_read_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: result outputs move only together with done
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) || !$stable(err_addr)) |-> done);

    // R5 / R6 / R7: only the three defined codes appear
    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);

    // R3: the cores never run while the memories are accessed
    a_r3_core_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_rd) |-> !core_rst_n);

endmodule

// File: tb/golden_result_monitor_bench.sv
module golden_result_monitor_bench;
    localparam int DEPTH   = 256;
    localparam int DW      = 8;
    localparam int TIMEOUT = 16;
    localparam int AW      = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dut_end = 1'b0;
    logic          ref_end = 1'b0;
    logic [DW-1:0] dut_rdata = '0;
    logic [DW-1:0] ref_rdata = '0;
    logic          core_rst_n, mem_we, mem_rd, done;
    logic [AW-1:0] mem_addr, err_addr;
    logic [DW-1:0] mem_wdata;
    logic [1:0]    status;

    logic          app_we = 1'b0;
    logic [AW-1:0] app_addr = '0;
    logic [DW-1:0] app_dut = '0;
    logic [DW-1:0] app_ref = '0;
    logic [DW-1:0] dut_mem [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];

    int n_chk = 0;
    int n_fail = 0;
    int clr_cnt, clr_bad, rd_cnt, rd_bad;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    golden_result_monitor #(.DEPTH(DEPTH), .DW(DW), .TIMEOUT(TIMEOUT)) u_golden_result_monitor (
        .clk(clk), .rst_n(rst_n), .start(start), .dut_end(dut_end), .ref_end(ref_end),
        .dut_rdata(dut_rdata), .ref_rdata(ref_rdata), .core_rst_n(core_rst_n),
        .mem_we(mem_we), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .status(status), .err_addr(err_addr)
    );

    // memory models of the two units
    always_ff @(posedge clk) begin
        if (mem_we) begin
            dut_mem[mem_addr] <= mem_wdata;
            ref_mem[mem_addr] <= mem_wdata;
        end
        if (app_we) begin
            dut_mem[app_addr] <= app_dut;
            ref_mem[app_addr] <= app_ref;
        end
        if (mem_rd) begin
            dut_rdata <= dut_mem[mem_addr];
            ref_rdata <= ref_mem[mem_addr];
        end
    end

    // port monitor for the clear and read walks (R2, R3, R4)
    always @(negedge clk) begin
        if (mem_we) begin
            if (int'(mem_addr) != clr_cnt || mem_wdata != '0 || core_rst_n) clr_bad++;
            clr_cnt++;
        end
        if (mem_rd) begin
            if (int'(mem_addr) != rd_cnt || core_rst_n) rd_bad++;
            rd_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // one experiment; fault addresses < 0 mean none, dut_dly < 0 means never
    task automatic run_case(input string req, input int f0, input int f1,
                            input int ref_dly, input int dut_dly, input bit extra_start,
                            input int exp_status, input int exp_addr, input int exp_reads);
        int guard;
        int last_c;
        clr_cnt = 0; clr_bad = 0; rd_cnt = 0; rd_bad = 0;
        pulse_start();
        if (extra_start) begin
            repeat (10) @(negedge clk);
            pulse_start();
        end
        guard = 0;
        while (!core_rst_n && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        for (int i = 0; i < 64; i++) begin
            app_we = 1'b1; app_addr = AW'(i);
            app_dut = DW'(i * 3 + 1); app_ref = DW'(i * 3 + 1);
            @(negedge clk);
        end
        if (f0 >= 0) begin
            app_addr = AW'(f0); app_dut = 8'h5A; app_ref = 8'hA5;
            @(negedge clk);
        end
        if (f1 >= 0) begin
            app_addr = AW'(f1); app_dut = 8'h11; app_ref = 8'h22;
            @(negedge clk);
        end
        app_we = 1'b0;
        if (extra_start) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        last_c = (dut_dly > ref_dly) ? dut_dly : ref_dly;
        for (int c = 0; c <= last_c; c++) begin
            ref_end = (c == ref_dly);
            dut_end = (c == dut_dly);
            @(negedge clk);
        end
        ref_end = 1'b0; dut_end = 1'b0;
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(req, "done seen", int'(done), 1);
        chk(req, "status", int'(status), exp_status);
        chk(req, "err_addr", int'(err_addr), exp_addr);
        chk("R2", "clear cycles", clr_cnt, DEPTH);
        chk("R2", "clear walk errors", clr_bad, 0);
        chk("R4", "read cycles", rd_cnt, exp_reads);
        chk("R4", "read walk errors", rd_bad, 0);
        @(negedge clk);
        chk("R9", "done width", int'(done), 0);
        repeat (5) @(negedge clk);
        chk("R9", "status held", int'(status), exp_status);
        chk("R9", "err_addr held", int'(err_addr), exp_addr);
    endtask

    task automatic t_reset();
        chk("R1", "done", int'(done), 0);
        chk("R1", "status", int'(status), 0);
        chk("R1", "err_addr", int'(err_addr), 0);
        chk("R1", "core_rst_n", int'(core_rst_n), 0);
        chk("R1", "mem_we", int'(mem_we), 0);
        chk("R1", "mem_rd", int'(mem_rd), 0);
    endtask

    task automatic t_clean_run();   // R5, R3
        run_case("R5", -1, -1, 6, 6, 1'b0, 0, 0, DEPTH);
    endtask

    task automatic t_two_mismatches();   // R6 lowest address wins
        run_case("R6", 8'h52, 8'h10, 4, 4, 1'b0, 1, 8'h10, DEPTH);
    endtask

    task automatic t_last_addr();   // R6 difference at DEPTH-1
        run_case("R6", DEPTH - 1, -1, 3, 3, 1'b0, 1, DEPTH - 1, DEPTH);
    endtask

    task automatic t_stale_cleared();   // R2 stale contents removed by clear
        @(negedge clk);
        app_we = 1'b1; app_addr = 8'hC0; app_dut = 8'hEE; app_ref = 8'h00;
        @(negedge clk) app_we = 1'b0;
        run_case("R2", -1, -1, 2, 2, 1'b0, 0, 0, DEPTH);
    endtask

    task automatic t_lost();   // R7
        run_case("R7", 8'h20, -1, 5, -1, 1'b0, 2, 0, 0);
    endtask

    task automatic t_late_ok();   // R8 late within grace
        run_case("R8", -1, -1, 2, 2 + TIMEOUT / 2, 1'b0, 0, 0, DEPTH);
    endtask

    task automatic t_early_dut();   // R8 dut ends before reference
        run_case("R8", 8'h33, -1, 12, 1, 1'b0, 1, 8'h33, DEPTH);
    endtask

    task automatic t_busy_start();   // R10 start while busy ignored
        run_case("R10", -1, -1, 3, 4, 1'b1, 0, 0, DEPTH);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_run();
        t_two_mismatches();
        t_last_addr();
        t_stale_cleared();
        t_lost();
        t_late_ok();
        t_early_dut();
        t_busy_start();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule